// File: doc/BRIEF.md
# Parallel TDM Port Frame Timing Generator

This block keeps byte-channel timing for a high-speed, byte-wide TDM port. On the receive side it follows a frame-start input sampled on the receive clock and numbers each byte of the frame. Three frame lengths are available through a two-bit rate code: 2048, 2430 and 810 channels, matching 16.384, 19.44 and 6.48 Mbyte/s. When the frame-start input goes quiet, the counter keeps running at the programmed frame length. When a frame-start is seen again, the counter snaps back to channel 0 on the next edge.

The transmit side has its own channel counter on its own clock. In modes where the transmit side shares the receive clock, the integrator ties `tx_clk` to `rx_clk`. This counter follows the same rate code and drives a transmit frame-start pin. That pin has programmable polarity and a programmable launch edge. A direction control turns the pin into an input. In that case an external device sets the transmit frame timing, so several ports can run side by side.

In both counters a change of the rate code is only taken at a frame boundary. The data path, channel switching and bus sharing are built around this block using its channel numbers and strobes.

Top module: `pfx_port_timing`

## Requirements
- R1: While `rst` is high, at each rising edge both counters go to 0 and both frame strobes go low. `tx_sync_o` then sits at its inactive level and `tx_sync_oe` follows the direction control.
- R2: With no frame boundary, `rx_chan` rises by exactly one per `rx_clk` rising edge.
- R3: Rate code 0 selects 2048 channels, 1 selects 2430, 2 selects 810 and 3 selects 2048. With no frame-start input, the counter runs to the last channel (length minus 1), wraps to 0, and raises `rx_sof` for that one cycle.
- R4: A high `rx_sync_i` at a rising edge forces `rx_chan` to 0 and `rx_sof` high after that edge, whatever the count was. If it is held high, the counter stays at 0.
- R5: A new rate code is latched only at a frame boundary (a wrap or a frame-start). The frame in progress keeps its old length.
- R6: The transmit counter uses the same lengths and rate latching. `tx_sof` is high for exactly the one cycle in which `tx_chan` is 0.
- R7: `tx_sync_o` shows the active level while the transmit strobe is high and the opposite level at all other times. The active level is high when `cfg_tx_pol` is 1 and low when it is 0.
- R8: With `cfg_tx_negedge` at 0, `tx_sync_o` changes just after the rising edge of `tx_clk`. With it at 1, the same waveform is launched half a cycle later, on the falling edge.
- R9: With `cfg_tx_ext` at 1, `tx_sync_oe` is 0. A rising edge that sees `tx_sync_i` at the active level (per `cfg_tx_pol`) restarts `tx_chan` at 0. With `cfg_tx_ext` at 0, `tx_sync_oe` is 1 and `tx_sync_i` has no effect on the transmit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive byte clock |
| tx_clk | input | 1 | Transmit byte clock (tie to rx_clk for shared-clock modes) |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Frame length code (0:2048, 1:2430, 2:810, 3:2048) |
| rx_sync_i | input | 1 | Receive frame-start, active high |
| tx_sync_i | input | 1 | Transmit frame-start from the pin when it is an input |
| cfg_tx_pol | input | 1 | Transmit frame-start active level (1 = high) |
| cfg_tx_negedge | input | 1 | Launch transmit frame-start on the falling edge |
| cfg_tx_ext | input | 1 | Transmit frame-start pin is an input |
| rx_chan | output | 12 | Receive channel number |
| rx_sof | output | 1 | Receive channel-0 strobe |
| tx_chan | output | 12 | Transmit channel number |
| tx_sof | output | 1 | Transmit channel-0 strobe |
| tx_sync_o | output | 1 | Transmit frame-start pin value |
| tx_sync_oe | output | 1 | Transmit frame-start pin drive enable |

## Verification
The assertions assume the following about the inputs:
- The configuration bits and the rate code are quasi-static relative to the clock.
- The rate code only ever names one of the four defined codes.
- The two clocks are free-running.
- Reset is released with the frame-start inputs inactive.

The stimulus changes every input only on falling edges. Configuration changes are made between clock edges, and the rate code is moved in the middle of frames so that the boundary-latching rule is exercised. Frame-start pulses are placed at arbitrary counts, including a held-high stretch, while the clocks keep running throughout.

// File: rtl/pfx_timing_pkg.sv
package pfx_timing_pkg;

  typedef enum logic [1:0] {
    RATE_16M = 2'd0,
    RATE_19M = 2'd1,
    RATE_6M  = 2'd2,
    RATE_ALT = 2'd3
  } rate_e;

  // Number of byte channels in a frame for a given rate code.
  function automatic int unsigned frame_len(
    input logic [1:0]  code,
    input int unsigned len_16m,
    input int unsigned len_19m,
    input int unsigned len_6m
  );
    case (rate_e'(code))
      RATE_19M: frame_len = len_19m;
      RATE_6M:  frame_len = len_6m;
      default:  frame_len = len_16m;
    endcase
  endfunction

endpackage

// File: rtl/pfx_chan_counter.sv
module pfx_chan_counter
  import pfx_timing_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned LEN_16M = 2048,
  parameter int unsigned LEN_19M = 2430,
  parameter int unsigned LEN_6M  = 810
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic             sync,
  output logic [CNT_W-1:0] chan,
  output logic             sof
);

  localparam logic [CNT_W-1:0] LAST_16M = CNT_W'(LEN_16M - 1);
  localparam logic [CNT_W-1:0] LAST_19M = CNT_W'(LEN_19M - 1);
  localparam logic [CNT_W-1:0] LAST_6M  = CNT_W'(LEN_6M - 1);

  logic [1:0]       rate_q;
  logic [CNT_W-1:0] last_q;
  logic             boundary;

  // Last channel of the frame currently being counted.
  always_comb begin
    case (rate_e'(rate_q))
      RATE_19M: last_q = LAST_19M;
      RATE_6M:  last_q = LAST_6M;
      default:  last_q = LAST_16M;
    endcase
  end

  assign boundary = sync || (chan >= last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan   <= '0;
      sof    <= 1'b0;
      rate_q <= rate_sel;
    end else if (boundary) begin
      chan   <= '0;
      sof    <= 1'b1;
      rate_q <= rate_sel;
    end else begin
      chan   <= chan + 1'b1;
      sof    <= 1'b0;
    end
  end

  // R2: plain increment away from a boundary
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!sync && chan != last_q) |=> (chan == $past(chan) + 1'b1) && !sof);

  // R3: wrap from the last channel with a strobe
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (!sync && chan == last_q) |=> (chan == '0) && sof);

  // R3: count never exceeds the frame
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    chan <= last_q);

  // R4: immediate resynchronisation
  a_r4_resync: assert property (@(posedge clk) disable iff (rst)
    sync |=> (chan == '0) && sof);

  // R5: rate only moves at a boundary
  a_r5_rate_hold: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(rate_q));

endmodule

// File: rtl/pfx_tx_launch.sv
module pfx_tx_launch (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic pol,
  input  logic neg_sel,
  output logic sync_o
);

  logic neg_q;
  logic level;

  // Falling-edge copy of the rising-edge strobe.
  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= sof;
  end

  assign level  = neg_sel ? neg_q : sof;
  assign sync_o = pol ? level : ~level;

  // R8: falling-edge copy holds the strobe of the current cycle at each rising edge
  a_r8_neg_tracks: assert property (@(posedge clk) disable iff (rst)
    neg_q == sof);

endmodule

// File: rtl/pfx_port_timing.sv
module pfx_port_timing
  import pfx_timing_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned LEN_16M = 2048,
  parameter int unsigned LEN_19M = 2430,
  parameter int unsigned LEN_6M  = 810
) (
  input  logic             rx_clk,
  input  logic             tx_clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic             rx_sync_i,
  input  logic             tx_sync_i,
  input  logic             cfg_tx_pol,
  input  logic             cfg_tx_negedge,
  input  logic             cfg_tx_ext,
  output logic [CNT_W-1:0] rx_chan,
  output logic             rx_sof,
  output logic [CNT_W-1:0] tx_chan,
  output logic             tx_sof,
  output logic             tx_sync_o,
  output logic             tx_sync_oe
);

  logic tx_ext_hit;

  assign tx_ext_hit = cfg_tx_ext && (tx_sync_i == cfg_tx_pol);
  assign tx_sync_oe = ~cfg_tx_ext;

  pfx_chan_counter #(
    .CNT_W(CNT_W), .LEN_16M(LEN_16M), .LEN_19M(LEN_19M), .LEN_6M(LEN_6M)
  ) u_rx_cnt (
    .clk(rx_clk), .rst(rst), .rate_sel(rate_sel), .sync(rx_sync_i),
    .chan(rx_chan), .sof(rx_sof)
  );

  pfx_chan_counter #(
    .CNT_W(CNT_W), .LEN_16M(LEN_16M), .LEN_19M(LEN_19M), .LEN_6M(LEN_6M)
  ) u_tx_cnt (
    .clk(tx_clk), .rst(rst), .rate_sel(rate_sel), .sync(tx_ext_hit),
    .chan(tx_chan), .sof(tx_sof)
  );

  pfx_tx_launch u_tx_launch (
    .clk(tx_clk), .rst(rst), .sof(tx_sof), .pol(cfg_tx_pol),
    .neg_sel(cfg_tx_negedge), .sync_o(tx_sync_o)
  );

  // R9: an external frame-start at the active level restarts the transmit count
  a_r9_ext_restart: assert property (@(posedge tx_clk) disable iff (rst)
    (cfg_tx_ext && tx_sync_i == cfg_tx_pol) |=> (tx_chan == '0) && tx_sof);

  // R7: outside the strobe the pin rests at the inactive level
  a_r7_idle: assert property (@(posedge tx_clk) disable iff (rst)
    (!cfg_tx_negedge && !tx_sof) |-> (tx_sync_o != cfg_tx_pol));

  // R6: strobe only on channel 0
  a_r6_sof_chan0: assert property (@(posedge tx_clk) disable iff (rst)
    tx_sof |-> (tx_chan == '0));

endmodule

// File: tb/pfx_port_timing_test.sv
module pfx_port_timing_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  rate_sel = 2'd0;
  logic        rx_sync_i = 1'b0;
  logic        tx_sync_i = 1'b0;
  logic        cfg_tx_pol = 1'b1;
  logic        cfg_tx_negedge = 1'b0;
  logic        cfg_tx_ext = 1'b0;
  logic [11:0] rx_chan, tx_chan;
  logic        rx_sof, tx_sof, tx_sync_o, tx_sync_oe;

  int total = 0;
  int bad = 0;

  pfx_port_timing uut (
    .rx_clk(clk), .tx_clk(clk), .rst(rst), .rate_sel(rate_sel),
    .rx_sync_i(rx_sync_i), .tx_sync_i(tx_sync_i), .cfg_tx_pol(cfg_tx_pol),
    .cfg_tx_negedge(cfg_tx_negedge), .cfg_tx_ext(cfg_tx_ext),
    .rx_chan(rx_chan), .rx_sof(rx_sof), .tx_chan(tx_chan), .tx_sof(tx_sof),
    .tx_sync_o(tx_sync_o), .tx_sync_oe(tx_sync_oe)
  );

  typedef struct {
    int    rxc;
    bit    rxs;
    int    txc;
    bit    txs;
    bit    tso;
    bit    toe;
    string tag;
  } item_t;

  item_t exp_q[$];

  // reference state
  int m_rxc, m_txc;
  bit [1:0] m_rxr, m_txr;
  bit m_rxs, m_txs;

  function automatic int flen(bit [1:0] c);
    case (c)
      2'd1: return 2430;
      2'd2: return 810;
      default: return 2048;
    endcase
  endfunction

  // compute the expected state after the coming rising edge and queue it
  task automatic drive(bit rs, bit ts);
    item_t it;
    bit rx_b, tx_act, tx_b, prev, lvl;
    rx_sync_i = rs;
    tx_sync_i = ts;
    rx_b   = rs || (m_rxc == flen(m_rxr) - 1);
    tx_act = cfg_tx_ext && (ts == cfg_tx_pol);
    tx_b   = tx_act || (m_txc == flen(m_txr) - 1);
    if (rs)                       it.tag = "R4";
    else if (rx_b)                it.tag = "R3";
    else if (tx_act)              it.tag = "R9";
    else if (rate_sel != m_rxr)   it.tag = "R5";
    else if (cfg_tx_negedge)      it.tag = "R8";
    else if (!cfg_tx_pol)         it.tag = "R7";
    else if (tx_b)                it.tag = "R6";
    else                          it.tag = "R2";
    if (rx_b) begin m_rxc = 0; m_rxs = 1; m_rxr = rate_sel; end
    else begin m_rxc++; m_rxs = 0; end
    prev = m_txs;
    if (tx_b) begin m_txc = 0; m_txs = 1; m_txr = rate_sel; end
    else begin m_txc++; m_txs = 0; end
    lvl = cfg_tx_negedge ? prev : m_txs;
    it.rxc = m_rxc; it.rxs = m_rxs; it.txc = m_txc; it.txs = m_txs;
    it.tso = cfg_tx_pol ? lvl : !lvl;
    it.toe = !cfg_tx_ext;
    exp_q.push_back(it);
  endtask

  task automatic step(bit rs, bit ts);
    @(negedge clk);
    drive(rs, ts);
  endtask

  task automatic run(int n);
    repeat (n) step(1'b0, !cfg_tx_pol);
  endtask

  task automatic reconfig(bit pol, bit neg, bit ext, bit [1:0] rate);
    @(negedge clk);
    cfg_tx_pol = pol; cfg_tx_negedge = neg; cfg_tx_ext = ext; rate_sel = rate;
    drive(1'b0, !pol);
  endtask

  task automatic check1(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // monitor: pop one expected item after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        bit ok;
        it = exp_q.pop_front();
        ok = (rx_chan == it.rxc) && (rx_sof == it.rxs) && (tx_chan == it.txc) &&
             (tx_sof == it.txs) && (tx_sync_o == it.tso) && (tx_sync_oe == it.toe);
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s actual rx=%0d/%0b tx=%0d/%0b pin=%0b oe=%0b expected rx=%0d/%0b tx=%0d/%0b pin=%0b oe=%0b at %0t",
                   it.tag, rx_chan, rx_sof, tx_chan, tx_sof, tx_sync_o, tx_sync_oe,
                   it.rxc, it.rxs, it.txc, it.txs, it.tso, it.toe, $time);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check1("R1", "rx_chan", rx_chan, 0);
    check1("R1", "rx_sof", rx_sof, 0);
    check1("R1", "tx_chan", tx_chan, 0);
    check1("R1", "tx_sof", tx_sof, 0);
    check1("R1", "tx_sync_o", tx_sync_o, 0);
    check1("R1", "tx_sync_oe", tx_sync_oe, 1);
    m_rxc = 0; m_txc = 0; m_rxs = 0; m_txs = 0; m_rxr = rate_sel; m_txr = rate_sel;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0);

    // R2, R3: free run through a 2048 frame
    run(2060);
    // R4: resync mid-frame, then a held frame-start
    run(100);
    step(1'b1, 1'b0);
    run(5);
    repeat (3) step(1'b1, 1'b0);
    run(20);
    // R5: rate move mid-frame to 810, old length finishes first
    reconfig(1'b1, 1'b0, 1'b0, 2'd2);
    run(2048 + 1700);
    // R3: 2430 frames
    reconfig(1'b1, 1'b0, 1'b0, 2'd1);
    run(810 + 2440 + 20);
    // R3: code 3 behaves as 2048
    reconfig(1'b1, 1'b0, 1'b0, 2'd3);
    run(2100);
    // R7: active-low frame-start, short frames
    reconfig(1'b0, 1'b0, 1'b0, 2'd2);
    run(900);
    // R8: falling-edge launch, both polarities
    reconfig(1'b0, 1'b1, 1'b0, 2'd2);
    run(900);
    reconfig(1'b1, 1'b1, 1'b0, 2'd2);
    run(900);
    // R9: external transmit framing, active low then active high
    reconfig(1'b0, 1'b0, 1'b1, 2'd2);
    run(50);
    step(1'b0, 1'b0);
    run(30);
    reconfig(1'b1, 1'b0, 1'b1, 2'd2);
    run(40);
    step(1'b0, 1'b1);
    run(10);
    // R9: pin as output ignores tx_sync_i at active level
    reconfig(1'b1, 1'b0, 1'b0, 2'd2);
    run(10);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    run(10);

    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule